// File: doc/BRIEF.md
# Atomic Set/Clear GPIO Output Port

This block drives a bank of general-purpose output pins from a 32-bit register bus. Software can replace the whole pin word at once, or change an arbitrary subset of pins in a single bus write without first reading the current value. Pins that a write does not address keep their level.

Three word-aligned registers are decoded. A data register at byte offset 0x0 holds the pin levels and reads back. A combined set/clear register at offset 0x4 carries a set mask in its low half and a clear mask in its high half, so one write can raise some pins and drop others in the same clock edge; where both masks name the same pin, the set wins. A clear-only register at offset 0x8 drops every pin whose bit is written as 1. Both mask registers are write-only and read as zero. The read port is combinational from the address; writes land on the rising edge that samples the write strobe.

Top module: `gpio_atomic_port`

## Requirements
- R1: While and after reset (active-low `rst_n`), `pin_out` is 0x0000 and a read of offset 0x0 returns 0x00000000.
- R2: A write to offset 0x0 replaces all pins with `bus_wdata[15:0]` (upper data bits ignored); a read of offset 0x0 returns the pin word zero-extended to 32 bits.
- R3: A write to offset 0x4 drives high each pin n whose `bus_wdata[n]` is 1, for n in 0..15.
- R4: A write to offset 0x4 drives low each pin n whose `bus_wdata[n+16]` is 1.
- R5: When a write to offset 0x4 has both bit n and bit n+16 set, pin n ends high.
- R6: Zero bits in a write to offset 0x4 or 0x8 leave the corresponding pins unchanged.
- R7: A write to offset 0x8 drives low each pin n whose `bus_wdata[n]` is 1; bits 31:16 are ignored.
- R8: Reads of offsets 0x4 and 0x8 return 0x00000000.
- R9: A write changes `pin_out` only on the rising edge that samples `bus_we` high, all affected pins in that same edge; with `bus_we` low the pins hold.
- R10: A write to any other address (0xC or a non-word-aligned offset) leaves the pins unchanged, and a read of such an address returns 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_out | output | 16 | Output pin levels |

## Verification
Set/clear writes are tried with disjoint masks, fully overlapping masks and partial overlaps, which separates a correct set-over-clear priority from a clear-wins or a last-half-wins design. Random writes over all four word offsets plus misaligned addresses, each followed by a read sweep, tell apart a decoder that aliases addresses, a clear-only register that wrongly honours its upper half, and mask registers that leak data into reads. A check in the strobe cycle before the edge distinguishes a registered update from a combinational bypass.

// File: rtl/gpio_port_pkg.sv
// gpio_port_pkg
// Shared constants and types for the atomic set/clear GPIO port.
// Assumes word-aligned byte addressing with four word slots.
package gpio_port_pkg;

    // Word slot selected by a bus access
    typedef enum logic [1:0] {
        SLOT_DATA   = 2'd0,
        SLOT_SETCLR = 2'd1,
        SLOT_CLR    = 2'd2,
        SLOT_NONE   = 2'd3
    } slot_t;

    // Byte offsets of the decoded registers
    localparam int unsigned OFF_DATA   = 32'h0;
    localparam int unsigned OFF_SETCLR = 32'h4;
    localparam int unsigned OFF_CLR    = 32'h8;

endpackage

// File: rtl/gpio_reg_decode.sv
// gpio_reg_decode
// Turns the byte address into a register slot and one-hot write enables.
// Assumes exact address match: unused or misaligned addresses select nothing.
module gpio_reg_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output slot_t             slot,
    output logic              wr_data,
    output logic              wr_setclr,
    output logic              wr_clr
);

    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_SETCLR = ADDR_W'(OFF_SETCLR);
    localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFF_CLR);

    // Address compare to a register slot
    always_comb begin
        if (bus_addr == A_DATA) begin
            slot = SLOT_DATA;
        end else if (bus_addr == A_SETCLR) begin
            slot = SLOT_SETCLR;
        end else if (bus_addr == A_CLR) begin
            slot = SLOT_CLR;
        end else begin
            slot = SLOT_NONE;
        end
    end

    // Qualify the slot with the write strobe
    always_comb begin
        wr_data   = bus_we && (slot == SLOT_DATA);
        wr_setclr = bus_we && (slot == SLOT_SETCLR);
        wr_clr    = bus_we && (slot == SLOT_CLR);
    end

endmodule

// File: rtl/gpio_pin_update.sv
// gpio_pin_update
// Computes the next level of every pin from the current level and one write.
// Per pin, priority is: full load, then set, then clear, then hold.
// Assumes at most one of the three write enables is high (guaranteed by decode).
module gpio_pin_update #(
    parameter int PIN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic [PIN_W-1:0]  cur,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_data,
    input  logic              wr_setclr,
    input  logic              wr_clr,
    output logic [PIN_W-1:0]  nxt
);

    localparam int CLR_BASE = DATA_W / 2;

    logic [PIN_W-1:0] set_mask;
    logic [PIN_W-1:0] clr_mask;

    // Build the set and clear masks for this cycle
    always_comb begin
        set_mask = wr_setclr ? wdata[PIN_W-1:0] : '0;
        clr_mask = '0;
        if (wr_setclr) begin
            clr_mask = wdata[CLR_BASE +: PIN_W];
        end else if (wr_clr) begin
            clr_mask = wdata[PIN_W-1:0];
        end
    end

    // One update cell per pin
    for (genvar i = 0; i < PIN_W; i++) begin : g_cell
        assign nxt[i] = wr_data     ? wdata[i] :
                        set_mask[i] ? 1'b1     :
                        clr_mask[i] ? 1'b0     :
                                      cur[i];
    end

endmodule

// File: rtl/gpio_read_mux.sv
// gpio_read_mux
// Selects read data for the addressed slot; mask registers read as zero.
// Assumes PIN_W is at most DATA_W/2.
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int PIN_W  = 16,
    parameter int DATA_W = 32
) (
    input  slot_t             slot,
    input  logic [PIN_W-1:0]  pins,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD_W = DATA_W - PIN_W;

    // Only the data slot returns state
    always_comb begin
        if (slot == SLOT_DATA) begin
            rdata = {{PAD_W{1'b0}}, pins};
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/gpio_atomic_port.sv
// gpio_atomic_port
// GPIO output bank with a data register, a combined set/clear register and a
// clear-only register. All pins change together on the edge sampling bus_we.
// Assumes synchronous active-low reset and PIN_W <= DATA_W/2.
module gpio_atomic_port
    import gpio_port_pkg::*;
#(
    parameter int PIN_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [PIN_W-1:0]  pin_out
);

    slot_t            slot;
    logic             wr_data;
    logic             wr_setclr;
    logic             wr_clr;
    logic [PIN_W-1:0] pins_q;
    logic [PIN_W-1:0] pins_d;

    gpio_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .slot      (slot),
        .wr_data   (wr_data),
        .wr_setclr (wr_setclr),
        .wr_clr    (wr_clr)
    );

    gpio_pin_update #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_update (
        .cur       (pins_q),
        .wdata     (bus_wdata),
        .wr_data   (wr_data),
        .wr_setclr (wr_setclr),
        .wr_clr    (wr_clr),
        .nxt       (pins_d)
    );

    gpio_read_mux #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_rmux (
        .slot  (slot),
        .pins  (pins_q),
        .rdata (bus_rdata)
    );

    // Single output register for the whole pin word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= '0;
        end else begin
            pins_q <= pins_d;
        end
    end

    assign pin_out = pins_q;

endmodule

// File: rtl/gpio_atomic_port_chk.sv
// gpio_atomic_port_chk
// Temporal checks on the port-level behaviour of gpio_atomic_port.
// Assumes the default register offsets from gpio_port_pkg.
module gpio_atomic_port_chk
    import gpio_port_pkg::*;
#(
    parameter int PIN_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PIN_W-1:0]  pin_out
);

    localparam int CLR_BASE = DATA_W / 2;
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_SETCLR = ADDR_W'(OFF_SETCLR);
    localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFF_CLR);

    logic rst_seen;

    // Note the first cycle out of reset so $past never reaches pre-reset values
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n ? 1'b1 : rst_seen;
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
        !bus_we |=> $stable(pin_out)); // R9

    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
        (bus_we && bus_addr == A_DATA) |=> (pin_out == $past(bus_wdata[PIN_W-1:0]))); // R2

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
        (bus_we && bus_addr == A_SETCLR) |=>
        ((pin_out & $past(bus_wdata[PIN_W-1:0])) == $past(bus_wdata[PIN_W-1:0]))); // R5

    AST_SETCLR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
        (bus_we && bus_addr == A_SETCLR) |=>
        ((pin_out & $past(bus_wdata[CLR_BASE +: PIN_W]) & ~$past(bus_wdata[PIN_W-1:0])) == '0)); // R4

    AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n || !rst_seen)
        (bus_we && bus_addr == A_CLR) |=>
        (pin_out == ($past(pin_out) & ~$past(bus_wdata[PIN_W-1:0])))); // R7

    AST_MASK_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_SETCLR || bus_addr == A_CLR) |-> (bus_rdata == '0)); // R8

    AST_DATA_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_DATA) |-> (bus_rdata[PIN_W-1:0] == pin_out)); // R2

endmodule

bind gpio_atomic_port gpio_atomic_port_chk #(
    .PIN_W  (PIN_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out)
);

// File: tb/gpio_atomic_port_test.sv
// gpio_atomic_port_test
// Directed corner cases plus seeded random writes, checked against a bench model.
module gpio_atomic_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_out;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic [15:0] model = '0;
    bit          done = 1'b0;

    gpio_atomic_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_out   (pin_out)
    );

    always #10 clk = ~clk;

    // Expected next pin word from the requirements
    function automatic logic [15:0] next_pins(input logic [15:0] cur,
                                              input logic [3:0] a,
                                              input logic [31:0] d);
        case (a)
            4'h0:    return d[15:0];                      // R2
            4'h4:    return (cur & ~d[31:16]) | d[15:0];  // R3 R4 R5 R6
            4'h8:    return cur & ~d[15:0];               // R7 R6
            default: return cur;                          // R10
        endcase
    endfunction

    // Expected read data from the requirements
    function automatic logic [31:0] read_exp(input logic [15:0] cur, input logic [3:0] a);
        return (a == 4'h0) ? {16'h0, cur} : 32'h0;  // R2 R8 R10
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus write; checks pins before and after the sampling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        #2 check("R9 no early change", {16'h0, pin_out}, {16'h0, model});
        @(negedge clk);
        bus_we = 1'b0;
        model = next_pins(model, a, d);
        check(req, {16'h0, pin_out}, {16'h0, model});
    endtask

    task automatic rd(input logic [3:0] a, input string req);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #2 check(req, bus_rdata, read_exp(model, a));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] addrs [6] = '{4'h0, 4'h4, 4'h8, 4'hC, 4'h2, 4'h5};
        void'($urandom(32'd1234));
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 pins in reset", {16'h0, pin_out}, 32'h0);
        rst_n = 1'b1;
        rd(4'h0, "R1 data read after reset");
        check("R1 pins after reset", {16'h0, pin_out}, 32'h0);

        wr(4'h0, 32'hFFFF_A5C3, "R2 full load, upper ignored");
        rd(4'h0, "R2 readback");
        wr(4'h4, 32'h0000_0010, "R3 set one pin");
        wr(4'h4, 32'h0081_0000, "R4 clear two pins");
        wr(4'h4, 32'h00F0_00F0, "R5 set wins on full overlap");
        wr(4'h4, 32'h0F00_0300, "R5 partial overlap");
        wr(4'h4, 32'h0000_0000, "R6 zero setclr holds");
        wr(4'h8, 32'h0000_0000, "R6 zero clr holds");
        wr(4'h8, 32'hFFFF_000F, "R7 clr low bits, upper ignored");
        rd(4'h4, "R8 setclr reads zero");
        rd(4'h8, "R8 clr reads zero");
        wr(4'hC, 32'hFFFF_FFFF, "R10 unmapped write ignored");
        wr(4'h1, 32'h0000_0000, "R10 misaligned write ignored");
        rd(4'hC, "R10 unmapped read zero");
        // R9: idle cycles hold
        repeat (4) @(negedge clk);
        check("R9 hold while idle", {16'h0, pin_out}, {16'h0, model});

        for (int i = 0; i < 400; i++) begin
            logic [3:0]  a;
            logic [31:0] d;
            a = addrs[$urandom_range(0, 5)];
            d = $urandom();
            wr(a, d, "R2-R7 random write");
            if (i % 8 == 0) begin
                for (int k = 0; k < 6; k++) rd(addrs[k], "R8 R10 read sweep");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule